// File: doc/BRIEF.md
# Self-Clocked Disk Write Encoder

This block models the write path of a disk channel in which the drive, not the controller, owns the write timing. A free-running flux clock at the bit-cell half rate (1.44 MHz in the target system) is divided by two into a phase signal. The phase marks each half-cell as the clock portion or the data portion of a bit cell. The controller side never forms pulses. For each half-cell it presents a steady active-low write-data level. The drive side turns that level into a flux reversal by toggling a head-current flip-flop on the rising clock edge that ends any half-cell in which write-data is low.

The controller always asserts write-data in the clock portion of a written cell, so every written cell carries a clock reversal. In the data portion it asserts write-data only for a one bit. A one-cycle request strobe asks the upstream source for the next serial bit. That strobe covers the clock portion, one half-cell before the data portion that uses the bit. Write enable is sampled once per cell, so cells are always written whole.

Top module: `selfclk_write_enc`

## Requirements
- R1: During reset, and in the first cycle after reset, `phaseData` is 0, which marks the clock portion. Outside reset it inverts on every rising clock edge, so a value of 1 marks the data portion.
- R2: In the clock portion of an active cell, `writeDataN` is 0.
- R3: In the data portion of an active cell, `writeDataN` is 0 when the captured bit is 1 and 1 when the captured bit is 0.
- R4: `headState` inverts at a rising clock edge when `writeDataN` is 0 in the cycle before that edge. Otherwise it keeps its value.
- R5: `bitReq` is 1 exactly during the clock portion of an active cell. `dataBit` is captured at the edge that ends that portion. Any value on `dataBit` during the data portion has no effect on `writeDataN`.
- R6: `writeEn` is sampled only at the edge that ends a data portion, and the sampled value decides whether the whole next cell is active. Changes to `writeEn` during a clock portion have no effect on that cell.
- R7: In an inactive cell, `writeDataN` is 1 in both halves, `bitReq` is 0 and `headState` is unchanged.
- R8: A synchronous active-high reset clears `headState` to 0 and makes the cell inactive. The first cell after reset is therefore inactive, whatever `writeEn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running flux clock from the drive |
| rst | input | 1 | Synchronous reset, active high |
| writeEn | input | 1 | Write request, sampled once per cell |
| dataBit | input | 1 | Serial bit from the upstream source |
| bitReq | output | 1 | Request for the next bit, high during the clock portion of an active cell |
| phaseData | output | 1 | Half-cell phase: 0 for the clock portion, 1 for the data portion |
| writeDataN | output | 1 | Steady active-low write-data level |
| headState | output | 1 | Head-current flip-flop state |

## Verification
The bound checker checks, on every cycle, that the phase alternates, that a request always coincides with a low write-data level in the clock portion, and that the head flip-flop toggles or holds exactly as the previous write-data level dictates. It also checks that an idle clock portion stays idle through its data portion. Only the bench's scenarios can show the data relations. These are that the level in each data portion matches the bit presented during the request, that the bus value during the data portion is ignored, and that enable changes take effect on cell boundaries. The bench also shows that the accumulated head state equals the parity of clock reversals plus one bits, over exhaustive data words and enable masks.

// File: rtl/selfclk_write_pkg.sv
package selfclk_write_pkg;

  // Strobes passed from the cell controller to the datapath.
  typedef struct packed {
    logic inData;      // current half-cell is the data portion
    logic cellActive;  // the current cell is being written
    logic captureBit;  // capture the serial bit at the coming edge
    logic requestBit;  // ask the source for a bit this half-cell
  } ctrlStrobes_t;

  localparam logic PHASE_CLOCK = 1'b0;
  localparam logic PHASE_DATA  = 1'b1;

endpackage

// File: rtl/selfclk_write_ctrl.sv
module selfclk_write_ctrl
  import selfclk_write_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         writeEn,
  output ctrlStrobes_t strobes
);

  logic phaseQ;
  logic activeQ;
  logic cellEnd;

  // A cell ends at the edge that closes its data portion.
  assign cellEnd = (phaseQ == PHASE_DATA);

  // Divide-by-two phase generator.
  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PHASE_CLOCK;
    else     phaseQ <= ~phaseQ;
  end

  // Write enable is sampled only on cell boundaries.
  always_ff @(posedge clk) begin
    if (rst)          activeQ <= 1'b0;
    else if (cellEnd) activeQ <= writeEn;
  end

  always_comb begin
    strobes.inData     = phaseQ;
    strobes.cellActive = activeQ;
    strobes.captureBit = activeQ & (phaseQ == PHASE_CLOCK);
    strobes.requestBit = activeQ & (phaseQ == PHASE_CLOCK);
  end

endmodule

// File: rtl/selfclk_write_dpath.sv
module selfclk_write_dpath
  import selfclk_write_pkg::*;
#(
  parameter logic HEAD_INIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic         dataBit,
  output logic         writeDataN,
  output logic         headState
);

  logic heldBit;
  logic assertLevel;
  logic headQ;

  // Bit register, held from the clock portion through the data portion.
  always_ff @(posedge clk) begin
    if (rst)                     heldBit <= 1'b0;
    else if (strobes.captureBit) heldBit <= dataBit;
  end

  // Level logic: clock portion always asserted, data portion only for ones.
  always_comb begin
    if (!strobes.cellActive)  assertLevel = 1'b0;
    else if (!strobes.inData) assertLevel = 1'b1;
    else                      assertLevel = heldBit;
  end

  assign writeDataN = ~assertLevel;

  // Drive-side toggle flip-flop for the head current.
  always_ff @(posedge clk) begin
    if (rst)              headQ <= HEAD_INIT;
    else if (!writeDataN) headQ <= ~headQ;
  end

  assign headState = headQ;

endmodule

// File: rtl/selfclk_write_enc.sv
module selfclk_write_enc
  import selfclk_write_pkg::*;
#(
  parameter logic HEAD_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic writeEn,
  input  logic dataBit,
  output logic bitReq,
  output logic phaseData,
  output logic writeDataN,
  output logic headState
);

  ctrlStrobes_t strobes;

  selfclk_write_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .writeEn (writeEn),
    .strobes (strobes)
  );

  selfclk_write_dpath #(.HEAD_INIT(HEAD_INIT)) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .dataBit    (dataBit),
    .writeDataN (writeDataN),
    .headState  (headState)
  );

  assign bitReq    = strobes.requestBit;
  assign phaseData = strobes.inData;

endmodule

// File: rtl/selfclk_write_chk.sv
module selfclk_write_chk (
  input logic clk,
  input logic rst,
  input logic bitReq,
  input logic phaseData,
  input logic writeDataN,
  input logic headState
);

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phaseData != $past(phaseData)));                      // R1

  AST_REQ_IN_CLOCK_HALF: assert property (@(posedge clk) disable iff (rst)
    bitReq |-> (!phaseData && !writeDataN));                        // R2

  AST_REQ_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    bitReq |=> (phaseData && !bitReq));                             // R5

  AST_HEAD_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    !writeDataN |=> (headState != $past(headState)));               // R4

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    writeDataN |=> $stable(headState));                             // R4

  AST_IDLE_CELL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!phaseData && writeDataN) |=> (writeDataN && !bitReq));        // R7

  AST_DATA_HALF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    phaseData |-> !bitReq);                                         // R5

endmodule

bind selfclk_write_enc selfclk_write_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .bitReq     (bitReq),
  .phaseData  (phaseData),
  .writeDataN (writeDataN),
  .headState  (headState)
);

// File: tb/selfclk_write_enc_tb.sv
module selfclk_write_enc_tb_top;

  localparam int CLK_PERIOD = 694;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic writeEn = 1'b0;
  logic dataBit = 1'b0;
  logic bitReq, phaseData, writeDataN, headState;

  int checks = 0;
  int errors = 0;
  logic expHead = 1'b0;
  logic curActive = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfclk_write_enc dut_i (
    .clk(clk), .rst(rst), .writeEn(writeEn), .dataBit(dataBit),
    .bitReq(bitReq), .phaseData(phaseData),
    .writeDataN(writeDataN), .headState(headState)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One cell; entered and left at a negedge inside a clock portion.
  task automatic runCell(input logic b, input logic enNext);
    chk("R1 phase clock half", phaseData, 1'b0);
    chk("R5 R7 request", bitReq, curActive);
    chk("R2 R7 clock level", writeDataN, ~curActive);
    chk("R4 head at cell start", headState, expHead);
    dataBit = b;
    writeEn = 1'b0;             // R6: ignored in the clock portion
    @(negedge clk);
    if (curActive) expHead = ~expHead;
    chk("R1 phase data half", phaseData, 1'b1);
    chk("R5 no request in data half", bitReq, 1'b0);
    chk("R3 R6 R7 data level", writeDataN, ~(curActive & b));
    chk("R4 head after clock half", headState, expHead);
    dataBit = ~b;               // R5: must be ignored
    writeEn = enNext;
    @(negedge clk);
    if (curActive && b) expHead = ~expHead;
    curActive = enNext;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset head", headState, 1'b0);
    chk("R8 R1 reset phase", phaseData, 1'b0);
    chk("R8 reset level", writeDataN, 1'b1);
    writeEn = 1'b1;
    rst = 1'b0;
    // R8: first cell after reset is idle even with writeEn high
    runCell(1'b1, 1'b1);
    // Exhaustive 8-bit words, enable held on
    for (int w = 0; w < 256; w++)
      for (int i = 7; i >= 0; i--) runCell(w[i], 1'b1);
    // Exhaustive 4-bit data against 4-bit enable masks
    for (int m = 0; m < 16; m++)
      for (int w = 0; w < 16; w++)
        for (int i = 3; i >= 0; i--) runCell(w[i], m[i]);
    // Mid-run reset during a data portion (R8)
    runCell(1'b1, 1'b1);
    dataBit = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears head", headState, 1'b0);
    chk("R8 reset phase", phaseData, 1'b0);
    chk("R8 reset idle level", writeDataN, 1'b1);
    chk("R8 reset no request", bitReq, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule